// File: doc/BRIEF.md
# Program Memory Wait-State Manager

This block sits on the instruction-fetch side of a CPU and chooses among three program stores using the 24-bit fetch address. Two small on-chip windows, a boot ROM at the bottom of the map and a fast RAM just below the 64 KiB boundary, answer in the same cycle. Every other address goes to an off-chip store, which gets its own read and write strobes and a programmable number of wait states.

While an off-chip access runs, the block holds the CPU's ready input low. It releases ready only when its wait counter has run out and the external ready line is high in the same cycle, so a slow memory controller can stretch any access further. The program-write strobe can also fill the fast RAM, which lets boot code copy time-critical routines into it. The 8-bit read data from the selected store is routed back to the CPU.

Top module: `pmem_wait_mgr`

## Requirements
- R1: An access with an address from 0x000000 to 0x0003FF selects the ROM. `rom_addr` equals address bits [9:0], `cpu_rdata` equals `rom_rdata`, and `cpu_ready` is high in the same cycle.
- R2: An access with an address from 0x00F000 to 0x00FFFF selects the RAM. `ram_addr` equals address bits [11:0], a read returns `ram_rdata`, and `cpu_ready` is high in the same cycle.
- R3: Addresses from 0x000400 to 0x00EFFF, and from 0x010000 upward, are off-chip. For these, `ext_rd` follows `cpu_rd`, `ext_wr` follows `cpu_wr`, and `ext_addr` equals the fetch address. An on-chip address never raises `ext_rd` or `ext_wr`.
- R4: Let N be the stored wait value and let `ext_ready` stay high. An off-chip access then keeps `cpu_ready` low for exactly N cycles, counted from its first cycle. `cpu_ready` is high in cycle N+1, and in that cycle a read returns `ext_rdata`.
- R5: During an off-chip access, `cpu_ready` is high only in a cycle where the wait count has expired and `ext_ready` is high. If `ext_ready` is held low for S cycles, an access takes max(N,S)+1 cycles.
- R6: With a stored wait value of 0, an off-chip access completes in its first cycle when `ext_ready` is high.
- R7: A `cpu_wr` in the RAM window pulses `ram_we` with `ram_wdata` equal to `cpu_wdata`, with no wait states. A `cpu_wr` in the ROM window is ignored: it raises neither `ram_we` nor `ext_wr`, and later ROM reads are unchanged.
- R8: `ws_load` stores `ws_value` (3 bits) into the wait value only in a cycle with no off-chip access in progress. Otherwise it is ignored, and the latency of later accesses shows which case applied.
- R9: A synchronous active-low reset ends any access in progress, returns the block to idle with `cpu_ready` high, and sets the wait value to 3.
- R10: With neither `cpu_rd` nor `cpu_wr` asserted, `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 24 | Fetch/write address from the CPU |
| cpu_rd | input | 1 | CPU program read strobe |
| cpu_wr | input | 1 | CPU program write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| cpu_ready | output | 1 | High when the current access completes |
| ws_load | input | 1 | Load request for the wait value |
| ws_value | input | 3 | Wait value to load |
| rom_addr | output | 10 | Local ROM address |
| rom_rdata | input | 8 | ROM read data |
| ram_addr | output | 12 | Local RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data |
| ext_addr | output | 24 | Off-chip address |
| ext_wdata | output | 8 | Off-chip write data |
| ext_rd | output | 1 | Off-chip read strobe |
| ext_wr | output | 1 | Off-chip write strobe |
| ext_rdata | input | 8 | Off-chip read data |
| ext_ready | input | 1 | Off-chip memory ready (can stretch an access) |

## Verification
The assertions assume the CPU holds its address, strobes and write data steady for as long as `cpu_ready` is low. They also assume `cpu_rd` and `cpu_wr` are never high together. The stimulus follows both rules: it changes the inputs only after a cycle in which ready was seen high, and it raises one strobe per access. `ext_ready` and `ws_load` are driven freely during off-chip accesses, because the design has to tolerate any pattern on them.

// File: rtl/pmem_pkg.sv
// Shared types for the program memory wait-state manager.
// Assumes: nothing beyond IEEE 1800-2017.
package pmem_pkg;
    typedef enum logic [1:0] {
        REG_ROM = 2'd0,
        REG_RAM = 2'd1,
        REG_EXT = 2'd2
    } pm_region_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } pm_state_e;
endpackage

// File: rtl/pmem_region_dec.sv
// Decodes a fetch address into one of three program regions.
// Assumes: the ROM window starts at 0 and the RAM window at RAM_BASE does not
// overlap the ROM window.
module pmem_region_dec
    import pmem_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int ROM_AW = 10,
    parameter int RAM_AW = 12,
    parameter logic [ADDR_W-1:0] RAM_BASE = 24'h00F000
) (
    input  logic [ADDR_W-1:0] addr,
    output pm_region_e        region
);
    localparam logic [ADDR_W-1:0] ROM_LIMIT = ADDR_W'(1) << ROM_AW;
    localparam logic [ADDR_W-1:0] RAM_LAST  = RAM_BASE + ((ADDR_W'(1) << RAM_AW) - ADDR_W'(1));

    // Compare the address against the window limits.
    always_comb begin
        if (addr < ROM_LIMIT) begin
            region = REG_ROM;
        end else if ((addr >= RAM_BASE) && (addr <= RAM_LAST)) begin
            region = REG_RAM;
        end else begin
            region = REG_EXT;
        end
    end
endmodule

// File: rtl/pmem_wait_ctl.sv
// Wait-state sequencer for off-chip accesses. It holds the programmable wait
// value and counts it down; done rises when the count has expired and the
// external ready is high in the same cycle.
// Assumes: ext_req stays high until done is seen.
module pmem_wait_ctl
    import pmem_pkg::*;
#(
    parameter int WS_W = 3,
    parameter int WS_RESET = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_req,
    input  logic            ext_ready,
    input  logic            ws_load,
    input  logic [WS_W-1:0] ws_value,
    output logic            done
);
    localparam logic [WS_W-1:0] WS_INIT = WS_W'(WS_RESET);
    localparam logic [WS_W-1:0] ONE     = WS_W'(1);

    pm_state_e       state_q;
    logic [WS_W-1:0] cnt_q;
    logic [WS_W-1:0] ws_q;
    logic            idle;

    assign idle = (state_q == ST_IDLE) && !ext_req;

    // Completion: both conditions must hold in the same cycle.
    always_comb begin
        if (state_q == ST_IDLE) begin
            done = ext_req && (ws_q == '0) && ext_ready;
        end else begin
            done = (cnt_q == '0) && ext_ready;
        end
    end

    // Sequencer state and the wait countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (ext_req && (ws_q != '0)) begin
                state_q <= ST_WAIT;
                cnt_q   <= ws_q - ONE;
            end
        end else if (done) begin
            state_q <= ST_IDLE;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Wait-value register, loadable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q <= WS_INIT;
        end else if (idle && ws_load) begin
            ws_q <= ws_value;
        end
    end

    // R5: completion always needs the external ready.
    p_done_needs_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ext_ready);
    // R4: no completion while wait cycles remain.
    p_no_early_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) && (cnt_q != '0)) |-> !done);
    // R8: the wait value does not move while an access is under way.
    p_ws_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT) || ext_req) |=> $stable(ws_q));
endmodule

// File: rtl/pmem_wait_mgr.sv
// Top of the program memory wait-state manager. It routes a CPU program
// access to the ROM, the RAM or off-chip memory, and drives cpu_ready.
// Assumes: the CPU holds address, strobes and write data while cpu_ready is
// low, and never raises cpu_rd and cpu_wr together.
module pmem_wait_mgr
    import pmem_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int ROM_AW = 10,
    parameter int RAM_AW = 12,
    parameter int WS_W = 3,
    parameter int WS_RESET = 3,
    parameter logic [ADDR_W-1:0] RAM_BASE = 24'h00F000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              ws_load,
    input  logic [WS_W-1:0]   ws_value,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_rd,
    output logic              ext_wr,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              ext_ready
);
    pm_region_e region;
    logic       req;
    logic       ext_req;
    logic       ext_done;

    pmem_region_dec #(
        .ADDR_W  (ADDR_W),
        .ROM_AW  (ROM_AW),
        .RAM_AW  (RAM_AW),
        .RAM_BASE(RAM_BASE)
    ) u_dec (
        .addr  (cpu_addr),
        .region(region)
    );

    assign req     = cpu_rd || cpu_wr;
    assign ext_req = req && (region == REG_EXT);

    pmem_wait_ctl #(
        .WS_W    (WS_W),
        .WS_RESET(WS_RESET)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_req  (ext_req),
        .ext_ready(ext_ready),
        .ws_load  (ws_load),
        .ws_value (ws_value),
        .done     (ext_done)
    );

    // Local addresses and write data fan out to every store.
    assign rom_addr  = cpu_addr[ROM_AW-1:0];
    assign ram_addr  = cpu_addr[RAM_AW-1:0];
    assign ram_wdata = cpu_wdata;
    assign ext_addr  = cpu_addr;
    assign ext_wdata = cpu_wdata;

    // Strobes go only to the selected store; ROM writes are dropped.
    assign ram_we = cpu_wr && (region == REG_RAM);
    assign ext_rd = cpu_rd && (region == REG_EXT);
    assign ext_wr = cpu_wr && (region == REG_EXT);

    // Ready: on-chip and idle cycles are immediate, off-chip waits.
    assign cpu_ready = ext_req ? ext_done : 1'b1;

    // Read-data return path selected by region.
    always_comb begin
        case (region)
            REG_ROM: cpu_rdata = rom_rdata;
            REG_RAM: cpu_rdata = ram_rdata;
            default: cpu_rdata = ext_rdata;
        endcase
    end

    // R1/R2: on-chip accesses never stall the CPU.
    p_onchip_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (region != REG_EXT)) |-> cpu_ready);
    // R3: off-chip strobes never fire for an on-chip address.
    p_ext_strobe_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd || ext_wr) |-> (region == REG_EXT));
    // R7: a RAM write completes in its own cycle.
    p_ram_we_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_ready && !ext_wr));
    // R10: with no strobe the CPU is never held.
    p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> cpu_ready);
endmodule

// File: tb/pmem_wait_mgr_tb.sv
module pmem_wait_mgr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        ws_load = 1'b0;
    logic [2:0]  ws_value = '0;
    logic [9:0]  rom_addr;
    logic [7:0]  rom_rdata;
    logic [11:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic [7:0]  ram_rdata;
    logic [23:0] ext_addr;
    logic [7:0]  ext_wdata;
    logic        ext_rd, ext_wr;
    logic [7:0]  ext_rdata;
    logic        ext_ready = 1'b1;

    int errors = 0;
    int checks = 0;
    int left = -1;
    int ws_m = 3;
    bit last_ready;
    int ram_sh [int];
    logic [7:0] ram_mem [4096];

    always #2 clk = ~clk;

    pmem_wait_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .ws_load(ws_load), .ws_value(ws_value),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rd(ext_rd),
        .ext_wr(ext_wr), .ext_rdata(ext_rdata), .ext_ready(ext_ready)
    );

    function automatic logic [7:0] rom_val(int a);
        return 8'((a & 255) ^ (a >> 8) ^ 8'hA5);
    endfunction
    function automatic logic [7:0] ext_val(int a);
        return 8'((a & 255) ^ ((a >> 8) & 255) ^ ((a >> 16) & 255) ^ 8'h3C);
    endfunction

    assign rom_rdata = rom_val(int'(rom_addr));
    assign ext_rdata = ext_val(int'(ext_addr));
    assign ram_rdata = ram_mem[ram_addr];
    always @(posedge clk) if (ram_we) ram_mem[ram_addr] <= ram_wdata;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock cycle: compare against the model mid-cycle, then advance it.
    task automatic cyc();
        int a;
        bit req, is_rom, is_ram, is_ext, er;
        int ln;
        string tg;
        #1;
        a = int'(cpu_addr);
        is_rom = a < 'h400;
        is_ram = (a >= 'hF000) && (a <= 'hFFFF);
        is_ext = !is_rom && !is_ram;
        req = cpu_rd || cpu_wr;
        ln = 0;
        er = 1'b1;
        if (req && is_ext) begin
            ln = (left < 0) ? ws_m : left;
            er = (ln == 0) && ext_ready;
        end
        if (rst_n) begin
            if (!req) tg = "R10";
            else if (is_rom) tg = "R1";
            else if (is_ram) tg = "R2";
            else if (!ext_ready) tg = "R5";
            else if (ws_m == 0) tg = "R6";
            else tg = "R4";
            chk(cpu_ready == er, {tg, " ready"}, int'(cpu_ready), int'(er));
            chk(ext_rd == (cpu_rd && is_ext), "R3 ext_rd", int'(ext_rd), int'(cpu_rd && is_ext));
            chk(ext_wr == (cpu_wr && is_ext), "R3 ext_wr", int'(ext_wr), int'(cpu_wr && is_ext));
            chk(ram_we == (cpu_wr && is_ram), "R7 ram_we", int'(ram_we), int'(cpu_wr && is_ram));
            if (req && is_rom) chk(int'(rom_addr) == (a & 'h3FF), "R1 rom_addr", int'(rom_addr), a & 'h3FF);
            if (req && is_ram) chk(int'(ram_addr) == (a & 'hFFF), "R2 ram_addr", int'(ram_addr), a & 'hFFF);
            if (req && is_ext) chk(int'(ext_addr) == a, "R3 ext_addr", int'(ext_addr), a);
            if (cpu_wr && is_ram) chk(ram_wdata == cpu_wdata, "R7 ram_wdata", int'(ram_wdata), int'(cpu_wdata));
            if (cpu_rd && er) begin
                if (is_rom) chk(cpu_rdata == rom_val(a), "R1 rdata", int'(cpu_rdata), int'(rom_val(a)));
                else if (is_ram) chk(int'(cpu_rdata) == ram_sh[a], "R2 rdata", int'(cpu_rdata), ram_sh[a]);
                else chk(cpu_rdata == ext_val(a), "R4 rdata", int'(cpu_rdata), int'(ext_val(a)));
            end
        end
        last_ready = er;
        @(posedge clk);
        if (!rst_n) begin
            left = -1;
            ws_m = 3;
        end else begin
            if (req && is_ext) left = er ? -1 : ((ln > 0) ? ln - 1 : 0);
            else begin
                left = -1;
                if (ws_load) ws_m = int'(ws_value);
            end
            if (cpu_wr && is_ram) ram_sh[a] = int'(cpu_wdata);
        end
        #1;
    endtask

    // Full access: hold inputs until ready, then check the total latency.
    task automatic access(int addr, bit rd, bit wr, int wd, int stall, string tag);
        int n = 0;
        int lat;
        bit ext;
        ext = !((addr < 'h400) || ((addr >= 'hF000) && (addr <= 'hFFFF)));
        lat = ext ? ((ws_m > stall ? ws_m : stall) + 1) : 1;
        cpu_addr = 24'(addr);
        cpu_rd = rd;
        cpu_wr = wr;
        cpu_wdata = 8'(wd);
        do begin
            ext_ready = (n >= stall);
            cyc();
            n++;
        end while (!last_ready && n < 40);
        chk(n == lat, {tag, " latency"}, n, lat);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        ext_ready = 1'b1;
    endtask

    task automatic load_ws(int v);
        ws_load = 1'b1;
        ws_value = 3'(v);
        cyc();
        ws_load = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
        cyc();
        cyc();
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(posedge clk);
        #1;
        do_reset();
        cyc();                                           // R9/R10 idle ready
        chk(cpu_ready == 1'b1, "R9 ready after reset", int'(cpu_ready), 1);
        access('h000000, 1, 0, 0, 0, "R1");
        access('h0003FF, 1, 0, 0, 0, "R1");
        access('h00F000, 0, 1, 'h5E, 0, "R7");
        access('h00FFFF, 0, 1, 'hC3, 0, "R7");
        access('h00F000, 1, 0, 0, 0, "R2");
        access('h00FFFF, 1, 0, 0, 0, "R2");
        access('h000010, 0, 1, 'hFF, 0, "R7 rom write");  // ignored
        access('h000010, 1, 0, 0, 0, "R7 rom unchanged");
        access('h000400, 1, 0, 0, 0, "R9 default R4");
        access('h00EFFF, 1, 0, 0, 0, "R3");
        access('h010000, 1, 0, 0, 0, "R3");
        access('h7FFFFF, 1, 0, 0, 0, "R3");
        access('h123456, 0, 1, 'h77, 0, "R3 write");
        load_ws(0);
        access('h020000, 1, 0, 0, 0, "R6");
        access('h020001, 1, 0, 0, 3, "R5 zero ws");
        load_ws(5);
        access('h030000, 1, 0, 0, 0, "R4");
        access('h030001, 1, 0, 0, 7, "R5");
        load_ws(2);
        access('h040000, 1, 0, 0, 2, "R5 equal");
        // R8: a load raised during an off-chip access must be ignored.
        ws_load = 1'b1;
        ws_value = 3'd6;
        access('h050000, 1, 0, 0, 0, "R8 during");
        ws_load = 1'b0;
        access('h050001, 1, 0, 0, 0, "R8 ignored");
        load_ws(7);
        access('h060000, 1, 0, 0, 0, "R8 accepted");
        // R9: reset in the middle of an off-chip access.
        cpu_addr = 24'h070000;
        cpu_rd = 1'b1;
        cyc();
        cyc();
        do_reset();
        cyc();
        chk(cpu_ready == 1'b1, "R9 ready after mid reset", int'(cpu_ready), 1);
        access('h070000, 1, 0, 0, 0, "R9 ws back to 3");
        access('h00F000, 1, 0, 0, 0, "R2 after reset");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule